// File: doc/BRIEF.md
# SPI Transfer Trigger Generator

This block issues single-cycle start pulses, each of which launches exactly one SPI transaction in an offload engine that streams DMA data to an SPI execution unit. It runs on the system clock, which has no fixed relation to the effective conversion rate of the attached device.

A build-time parameter picks one of two sources for the pulses.

- **Timer source (the default).** A down-counter reloads from a 16-bit rate word. Each time the counter expires it emits one pulse. This gives periods up to 65536 system clocks, which is kHz rates from a 100 MHz clock.
- **External source.** The device's data-ready line is treated as asynchronous. It passes through a chain of synchronizer flops, and each rising edge produces one pulse.

In both modes an enable input gates the output.

Top module: `spi_trig_gen`

## Requirements
- R1: While `rst` is high, `trig_out` is low.
- R2: Timer mode: with `trig_en` held high and a constant `rate_word` = N, `trig_out` is high for exactly one cycle in every N+1 cycles. The first pulse comes N+1 clock edges after the first edge that samples `trig_en` high.
- R3: Timer mode: with `rate_word` = 0 and `trig_en` held high, `trig_out` is high on every cycle.
- R4: While `trig_en` is sampled low, no pulse is produced in either mode. In timer mode the counter is held at the current `rate_word`, so re-enabling starts a full period.
- R5: Timer mode: a change of `rate_word` while enabled does not alter the period in progress. The new value governs the period that begins after the next pulse.
- R6: External mode (`ASYNC_TRIG`=1): if `drdy_in` is first sampled high at edge a after being low, `trig_out` is high for the one cycle following edge a+2.
- R7: External mode: a `drdy_in` that stays high, or that falls, produces no further pulse. Consecutive cycles never both carry a pulse.
- R8: External mode: if `trig_en` is low at the edge where a detected rise would emit its pulse, that pulse is dropped and is not deferred.
- R9: External mode: `rate_word` has no effect on `trig_out`.
- R10: Timer mode: the full 16-bit range is usable. `rate_word` = 16'hFFFF gives the first pulse 65536 edges after enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| trig_en | input | 1 | Enables pulse generation |
| rate_word | input | RATE_W (16) | Timer mode: period minus one, in clocks |
| drdy_in | input | 1 | Device data-ready line, asynchronous (external mode) |
| trig_out | output | 1 | Single-cycle start-of-transfer pulse |

## Verification
The bench goes after these corner cases, each paired with the wrong design it exposes:

- **Rate zero.** An off-by-one divider would stall here or pulse every other cycle.
- **Mid-period rate changes.** A design that truncates the running period would emit pulses early.
- **Disable and re-enable.** A counter that keeps its stale value would fire after a partial period.
- **Full 16-bit word.** A narrowed counter would wrap and fire far too soon.
- **External mode.** The bench checks the exact two-edge synchronizer latency. It checks that a held-high line gives a single pulse, where a level detector would give a pulse train. It also checks that a rise landing on a disabled cycle is lost rather than queued.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic {
    SRC_TIMER = 1'b0,
    SRC_EXT   = 1'b1
  } trig_src_e;

  // Clocks between successive pulses for a given rate word.
  function automatic int unsigned period_clocks(input int unsigned word);
    return word + 1;
  endfunction

  // Counter has run out when it reads all zeros.
  function automatic logic count_spent(input logic [31:0] cnt);
    return (cnt == 32'd0);
  endfunction

  // Rising edge of a synchronized level against its previous value.
  function automatic logic rose_now(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/trig_rate_div.sv
module trig_rate_div
  import trig_pkg::*;
#(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [RATE_W-1:0] cnt;
  logic              spent;

  assign spent = count_spent(32'(cnt));
  assign tick  = en & spent;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt <= '0;
    end else if (!en || spent) begin
      cnt <= rate;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == $past(rate)) else $error("counter not held");  // R4

  AST_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && rate != '0) |=> !tick) else $error("back-to-back tick");  // R2

  AST_ZERO_RATE: assert property (@(posedge clk) disable iff (rst)
    (tick && rate == '0) ##1 en |-> tick) else $error("rate 0 gap");  // R3

endmodule

// File: rtl/trig_sync_edge.sv
module trig_sync_edge
  import trig_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge rst) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = rose_now(chain[STAGES-1], prev);

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise) else $error("edge detected twice");  // R7

endmodule

// File: rtl/spi_trig_gen.sv
module spi_trig_gen
  import trig_pkg::*;
#(
  parameter int unsigned RATE_W      = 16,
  parameter bit          ASYNC_TRIG  = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_en,
  input  logic [RATE_W-1:0] rate_word,
  input  logic              drdy_in,
  output logic              trig_out
);

  localparam trig_src_e SRC = ASYNC_TRIG ? SRC_EXT : SRC_TIMER;

  logic timer_tick;
  logic ext_rise;
  logic fire;

  trig_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .en   (trig_en),
    .rate (rate_word),
    .tick (timer_tick)
  );

  trig_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (drdy_in),
    .rise (ext_rise)
  );

  assign fire = trig_en & ((SRC == SRC_EXT) ? ext_rise : timer_tick);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) trig_out <= 1'b0;
    else     trig_out <= fire;
  end

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> !trig_out) else $error("pulse during reset");  // R1

  AST_NO_TRIG_OFF: assert property (@(posedge clk) disable iff (rst)
    !trig_en |=> !trig_out) else $error("pulse while disabled");  // R4

  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (SRC == SRC_EXT && trig_out) |=> !trig_out) else $error("ext pulse train");  // R7

endmodule

// File: tb/tb_spi_trig_gen.sv
module tb_spi_trig_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] rate = 16'd0;
  logic        drdy = 1'b0;
  logic        trig_t;
  logic        trig_a;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // timer model state
  int unsigned ph = 0;
  int unsigned per = 1;
  // external model history
  bit a1 = 0, a2 = 0, a3 = 0;

  always #5 clk = ~clk;

  spi_trig_gen #(.RATE_W(16), .ASYNC_TRIG(1'b0)) dut (
    .clk(clk), .rst(rst), .trig_en(en), .rate_word(rate),
    .drdy_in(drdy), .trig_out(trig_t));

  spi_trig_gen #(.RATE_W(16), .ASYNC_TRIG(1'b1)) dut_a (
    .clk(clk), .rst(rst), .trig_en(en), .rate_word(rate),
    .drdy_in(drdy), .trig_out(trig_a));

  function automatic int unsigned next_period(input logic [15:0] w);
    return int'(w) + 1;
  endfunction

  task automatic check(input bit got, input bit exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at %0t: trig actual=%0b expected=%0b", req, $time, got, exp);
    end
  endtask

  task automatic step(input bit e, input logic [15:0] r, input bit d, input string tag);
    bit exp_t, exp_a, rose;
    string atag;
    @(negedge clk);
    en = e; rate = r; drdy = d;
    @(posedge clk);
    // timer model
    if (!e) begin
      exp_t = 0; ph = 0; per = next_period(r);
    end else begin
      ph++;
      exp_t = (ph == per);
      if (exp_t) begin ph = 0; per = next_period(r); end
    end
    // external model
    rose  = a2 && !a3;
    exp_a = e && rose;
    atag  = exp_a ? "R6 R9" : ((rose && !e) ? "R8" : "R7 R9");
    a3 = a2; a2 = a1; a1 = d;
    #1;
    check(trig_t, exp_t, tag);
    check(trig_a, exp_a, atag);
  endtask

  initial begin
    #(64'd10 * 64'd200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [15:0] r;
    bit e, d;
    seed = $urandom(32'h5eed);
    // R1: reset
    repeat (3) begin
      @(negedge clk); #1;
      check(trig_t, 1'b0, "R1");
      check(trig_a, 1'b0, "R1");
    end
    @(negedge clk); rst = 1'b0;
    step(0, 16'd4, 0, "R4");
    // R2: constant rate
    for (int i = 0; i < 40; i++) step(1, 16'd4, (i % 7) < 3, "R2");
    // R3: rate zero
    step(0, 16'd0, 0, "R4");
    for (int i = 0; i < 12; i++) step(1, 16'd0, 1, "R3");
    // R4: disable and re-enable mid-period
    step(0, 16'd9, 0, "R4");
    for (int i = 0; i < 5; i++) step(1, 16'd9, 0, "R4");
    for (int i = 0; i < 4; i++) step(0, 16'd9, (i == 0), "R4");
    for (int i = 0; i < 14; i++) step(1, 16'd9, 0, "R4");
    // R8: rise lands on disabled emit edge
    step(1, 16'd9, 1, "R8");
    step(1, 16'd9, 1, "R8");
    step(0, 16'd9, 1, "R8");
    for (int i = 0; i < 4; i++) step(1, 16'd9, 1, "R7");
    // R5: rate changes mid-period
    step(0, 16'd6, 0, "R5");
    for (int i = 0; i < 3; i++) step(1, 16'd6, 0, "R5");
    for (int i = 0; i < 30; i++) step(1, 16'd2, 0, "R5");
    for (int i = 0; i < 30; i++) step(1, (i % 2) ? 16'd11 : 16'd3, 0, "R5");
    // random mix
    r = 16'd3; e = 1; d = 0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) r = 16'($urandom_range(0, 20));
      if ($urandom_range(0, 15) == 0) e = ~e;
      if ($urandom_range(0, 3) == 0) d = ~d;
      step(e, r, d, "R2 R5");
    end
    // R10: full-width word
    step(0, 16'hFFFF, 0, "R10");
    for (int i = 0; i < 65540; i++) step(1, 16'hFFFF, 0, "R10");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule